// File: doc/BRIEF.md
# Bi-Mode Conditional Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using the branch address together with a register of recent branch directions. It holds two banks of direction counters. One bank starts out leaning towards taken and the other towards not-taken. A third table, indexed only by the branch address, chooses which bank gives the answer for each branch. Branches that mostly go one way are steered to the bank that matches them, so branches with opposite habits do not overwrite each other's counters when they hash to the same entry.

The fetch side presents a PC on the predict port and gets back, in the same cycle, a direction and a metadata word. The history register is advanced at the next clock edge using the predicted direction. The execute side returns the PC, the real outcome and the unchanged metadata word on the update port. The update port trains the counters. On a wrong guess it also rebuilds the history from the snapshot in the metadata plus the real outcome.

Top module: `bimode_predictor`

## Requirements
- R1: After reset, every counter in the taken-leaning bank reads 2 (weakly taken), every counter in the not-taken-leaning bank reads 1 (weakly not-taken), every choice counter reads 2, and the history register is zero. The first prediction after reset is therefore taken, and its metadata has the history field 0, the bank-select bit 1 and the direction bit 1.
- R2: Metadata is HIST_W+2 bits wide. Bits [HIST_W+1:2] hold the history register as it was when the prediction was made. Bit 1 holds the bank select (1 = taken-leaning bank). Bit 0 holds the predicted direction (1 = taken).
- R3: The direction banks are indexed by PC[IDX_W+1:2] XOR the history, with the history zero-extended to IDX_W bits. The choice table is indexed by PC[IDX_W+1:2].
- R4: Bit 1 of the choice counter selects the bank. The prediction is bit 1 of the selected bank's counter at the direction index.
- R5: In a cycle with a valid prediction and no mispredicted update, the history becomes {history[HIST_W-2:0], predicted direction} at the clock edge.
- R6: An update whose outcome differs from metadata bit 0 sets the history to {snapshot[HIST_W-2:0], outcome}. This repair overrides a prediction shift in the same cycle.
- R7: An update whose outcome equals metadata bit 0 leaves the history unchanged.
- R8: An update trains only the bank named by metadata bit 1, at the index formed from the update PC and the snapshot. The counter moves one step towards the outcome and saturates at 0 and 3.
- R9: The choice counter moves one step towards the outcome on every update, except when the bank select disagrees with the outcome but metadata bit 0 agrees with it. In that case the choice counter is left unchanged.
- R10: In a cycle with neither a valid prediction nor a mispredicted update, the history holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_valid_i | input | 1 | A prediction is taken this cycle |
| pred_pc_i | input | PC_W | PC of the branch being predicted |
| pred_taken_o | output | 1 | Predicted direction |
| pred_meta_o | output | HIST_W+2 | Metadata to carry with the branch |
| upd_valid_i | input | 1 | A resolved branch is reported this cycle |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Real direction of the resolved branch |
| upd_meta_i | input | HIST_W+2 | Metadata returned from the prediction |

## Verification
The bound checker watches the history field on every cycle. It checks the speculative shift, the repair after a mispredicted update (and that the repair wins over a same-cycle prediction), the hold when the block is idle, and the zero state just after reset. Counter training is not visible at the ports in the cycle it happens. Only scenarios can show it: the bench builds counter states on purpose and then reads a later prediction. This is how it shows that only the selected bank learns, that counters saturate, and that the choice counter is left unchanged in the exception case. A long mixed run with overlapping predictions and updates checks the indexing against a reference model.

// File: rtl/bimode_pkg.sv
package bimode_pkg;

   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_SNT = 2'd0;
   localparam ctr2_t CTR_WNT = 2'd1;
   localparam ctr2_t CTR_WT  = 2'd2;
   localparam ctr2_t CTR_ST  = 2'd3;

   // one saturating step towards the observed direction
   function automatic ctr2_t ctr_step(input ctr2_t cur, input logic dir);
      ctr2_t nxt;
      if (dir) nxt = (cur == CTR_ST)  ? cur : cur + 2'd1;
      else     nxt = (cur == CTR_SNT) ? cur : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/bimode_hash.sv
module bimode_hash #(
   parameter int PC_W   = 32,
   parameter int PC_LSB = 2,
   parameter int IDX_W  = 10,
   parameter int HIST_W = 10
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [HIST_W-1:0] hist,
   output logic [IDX_W-1:0]  dir_idx,
   output logic [IDX_W-1:0]  cho_idx
);
   logic [IDX_W-1:0] pc_bits;
   logic             pc_unused;

   assign pc_bits   = pc[PC_LSB +: IDX_W];
   assign pc_unused = ^pc;
   assign cho_idx   = pc_bits;

   generate
      if (HIST_W == IDX_W) begin : g_full
         assign dir_idx = pc_bits ^ hist;
      end else begin : g_pad
         assign dir_idx = pc_bits ^ {{(IDX_W-HIST_W){1'b0}}, hist};
      end
   endgenerate
endmodule

// File: rtl/bimode_ctr_table.sv
module bimode_ctr_table
   import bimode_pkg::*;
#(
   parameter int    IDX_W   = 10,
   parameter ctr2_t RST_VAL = CTR_WT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr2_t            rd_ctr,
   input  logic             trn_en,
   input  logic [IDX_W-1:0] trn_idx,
   input  logic             trn_dir
);
   localparam int ENTRIES = 1 << IDX_W;

   ctr2_t cells [ENTRIES];

   assign rd_ctr = cells[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) cells[i] <= RST_VAL;
      end else if (trn_en) begin
         cells[trn_idx] <= ctr_step(cells[trn_idx], trn_dir);
      end
   end
endmodule

// File: rtl/bimode_ghist.sv
module bimode_ghist #(
   parameter int HIST_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spec_en,
   input  logic              spec_dir,
   input  logic              fix_en,
   input  logic [HIST_W-2:0] fix_base,
   input  logic              fix_dir,
   output logic [HIST_W-1:0] hist
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hist <= '0;
      else if (fix_en)  hist <= {fix_base, fix_dir};
      else if (spec_en) hist <= {hist[HIST_W-2:0], spec_dir};
   end
endmodule

// File: rtl/bimode_predictor.sv
module bimode_predictor
   import bimode_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int PC_LSB = 2,
   parameter int IDX_W  = 10,
   parameter int HIST_W = 10,
   localparam int META_W = HIST_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pred_valid_i,
   input  logic [PC_W-1:0]   pred_pc_i,
   output logic              pred_taken_o,
   output logic [META_W-1:0] pred_meta_o,
   input  logic              upd_valid_i,
   input  logic [PC_W-1:0]   upd_pc_i,
   input  logic              upd_taken_i,
   input  logic [META_W-1:0] upd_meta_i
);
   generate
      if (HIST_W < 2 || HIST_W > IDX_W) begin : g_bad_hist
         $error("HIST_W must lie between 2 and IDX_W");
      end
      if (PC_W < PC_LSB + IDX_W) begin : g_bad_pc
         $error("PC_W too narrow for PC_LSB + IDX_W");
      end
   endgenerate

   logic [HIST_W-1:0] ghist;
   logic [IDX_W-1:0]  p_dir_idx, p_cho_idx, u_dir_idx, u_cho_idx;
   ctr2_t             cho_ctr;
   ctr2_t             bank_ctr [2];
   logic              p_sel, p_dir;
   logic [HIST_W-1:0] u_snap;
   logic              u_sel, u_pdir;
   logic              u_mispred, u_cho_keep;
   logic              ctr_unused;

   assign u_snap = upd_meta_i[META_W-1:2];
   assign u_sel  = upd_meta_i[1];
   assign u_pdir = upd_meta_i[0];

   bimode_hash #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_hash_p (
      .pc(pred_pc_i), .hist(ghist), .dir_idx(p_dir_idx), .cho_idx(p_cho_idx)
   );

   bimode_hash #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_hash_u (
      .pc(upd_pc_i), .hist(u_snap), .dir_idx(u_dir_idx), .cho_idx(u_cho_idx)
   );

   // choice stays put when it chose wrongly but its bank still got it right
   assign u_cho_keep = (u_sel != upd_taken_i) && (u_pdir == upd_taken_i);
   assign u_mispred  = upd_valid_i && (u_pdir != upd_taken_i);

   bimode_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WT)) u_choice (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(p_cho_idx), .rd_ctr(cho_ctr),
      .trn_en(upd_valid_i && !u_cho_keep), .trn_idx(u_cho_idx), .trn_dir(upd_taken_i)
   );

   // bank 0 leans not-taken, bank 1 leans taken
   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank
         localparam ctr2_t BANK_RST = (b == 1) ? CTR_WT : CTR_WNT;
         bimode_ctr_table #(.IDX_W(IDX_W), .RST_VAL(BANK_RST)) u_tbl (
            .clk(clk), .rst_n(rst_n),
            .rd_idx(p_dir_idx), .rd_ctr(bank_ctr[b]),
            .trn_en(upd_valid_i && (u_sel == 1'(b))),
            .trn_idx(u_dir_idx), .trn_dir(upd_taken_i)
         );
      end
   endgenerate

   assign p_sel        = cho_ctr[1];
   assign p_dir        = p_sel ? bank_ctr[1][1] : bank_ctr[0][1];
   assign pred_taken_o = p_dir;
   assign pred_meta_o  = {ghist, p_sel, p_dir};
   assign ctr_unused   = ^{cho_ctr[0], bank_ctr[0][0], bank_ctr[1][0], u_snap[HIST_W-1]};

   bimode_ghist #(.HIST_W(HIST_W)) u_ghist (
      .clk(clk), .rst_n(rst_n),
      .spec_en(pred_valid_i), .spec_dir(p_dir),
      .fix_en(u_mispred), .fix_base(u_snap[HIST_W-2:0]), .fix_dir(upd_taken_i),
      .hist(ghist)
   );
endmodule

// File: rtl/bimode_predictor_chk.sv
module bimode_predictor_chk #(
   parameter int HIST_W = 10,
   localparam int META_W = HIST_W + 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pred_valid_i,
   input logic              pred_taken_o,
   input logic [META_W-1:0] pred_meta_o,
   input logic              upd_valid_i,
   input logic              upd_taken_i,
   input logic [META_W-1:0] upd_meta_i
);
   logic [HIST_W-1:0] hist_seen;
   logic              mis;
   logic              chk_unused;

   assign hist_seen  = pred_meta_o[META_W-1:2];
   assign mis        = upd_valid_i && (upd_meta_i[0] != upd_taken_i);
   assign chk_unused = ^{pred_meta_o[1:0], upd_meta_i[META_W-1], upd_meta_i[1]};

   // R6
   repair_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mis |=> hist_seen == {$past(upd_meta_i[HIST_W:2]), $past(upd_taken_i)});

   // R5
   spec_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_valid_i && !mis) |=> hist_seen == {$past(hist_seen[HIST_W-2:0]), $past(pred_taken_o)});

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pred_valid_i && !mis) |=> $stable(hist_seen));

   // R1
   reset_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> hist_seen == '0);
endmodule

bind bimode_predictor bimode_predictor_chk #(.HIST_W(HIST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pred_valid_i(pred_valid_i), .pred_taken_o(pred_taken_o),
   .pred_meta_o(pred_meta_o), .upd_valid_i(upd_valid_i), .upd_taken_i(upd_taken_i),
   .upd_meta_i(upd_meta_i)
);

// File: tb/bimode_predictor_tb.sv
module bimode_predictor_tb;
   localparam int PC_W   = 32;
   localparam int IDX_W  = 10;
   localparam int HIST_W = 10;
   localparam int META_W = HIST_W + 2;
   localparam int ENT    = 1 << IDX_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pred_valid_i = 1'b0;
   logic [PC_W-1:0]   pred_pc_i = '0;
   logic              pred_taken_o;
   logic [META_W-1:0] pred_meta_o;
   logic              upd_valid_i = 1'b0;
   logic [PC_W-1:0]   upd_pc_i = '0;
   logic              upd_taken_i = 1'b0;
   logic [META_W-1:0] upd_meta_i = '0;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   bimode_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_dut (.*);

   // reference state built from the requirements
   logic [1:0]        m_tk [ENT];
   logic [1:0]        m_nt [ENT];
   logic [1:0]        m_ch [ENT];
   logic [HIST_W-1:0] m_h;

   logic [META_W:0] exp_q [$];
   string           tag_q [$];

   function automatic logic [1:0] step(input logic [1:0] c, input logic d);
      if (d) return (c == 2'd3) ? c : c + 2'd1;
      return (c == 2'd0) ? c : c - 2'd1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < ENT; i++) begin
         m_tk[i] = 2'd2; m_nt[i] = 2'd1; m_ch[i] = 2'd2;
      end
      m_h = '0;
   endtask

   task automatic note(input bit ok, input string req, input logic [META_W:0] act,
                       input logic [META_W:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0; pred_valid_i = 1'b0; upd_valid_i = 1'b0;
      repeat (3) @(posedge clk);
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one cycle of stimulus; expected prediction pushed to the scoreboard
   task automatic do_op(input logic pv, input logic [PC_W-1:0] ppc, input string tag,
                        input logic uv, input logic [PC_W-1:0] upc, input logic ut,
                        input logic [META_W-1:0] um, output logic [META_W-1:0] mo);
      logic [IDX_W-1:0] ci, di;
      logic sel, dir;
      @(posedge clk); #1;
      pred_valid_i = pv; pred_pc_i = ppc;
      upd_valid_i = uv; upd_pc_i = upc; upd_taken_i = ut; upd_meta_i = um;
      mo = '0; dir = 1'b0;
      if (pv) begin
         ci  = ppc[IDX_W+1:2];
         di  = ci ^ m_h;
         sel = m_ch[ci][1];
         dir = sel ? m_tk[di][1] : m_nt[di][1];
         mo  = {m_h, sel, dir};
         exp_q.push_back({dir, mo});
         tag_q.push_back(tag);
      end
      if (uv) begin
         ci = upc[IDX_W+1:2];
         di = ci ^ um[META_W-1:2];
         if (um[1]) m_tk[di] = step(m_tk[di], ut);
         else       m_nt[di] = step(m_nt[di], ut);
         if (!((um[1] != ut) && (um[0] == ut))) m_ch[ci] = step(m_ch[ci], ut);
      end
      if (uv && (um[0] != ut)) m_h = {um[HIST_W:2], ut};
      else if (pv)             m_h = {m_h[HIST_W-2:0], dir};
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         pred_valid_i = 1'b0; upd_valid_i = 1'b0;
      end
   endtask

   task automatic pred(input logic [PC_W-1:0] pc, input string tag, output logic [META_W-1:0] mo);
      do_op(1'b1, pc, tag, 1'b0, '0, 1'b0, '0, mo);
   endtask

   task automatic upd(input logic [PC_W-1:0] pc, input logic t, input logic [META_W-1:0] m);
      logic [META_W-1:0] dummy;
      do_op(1'b0, '0, "", 1'b1, pc, t, m, dummy);
   endtask

   // monitor: compare outputs against the queue away from the clock edge
   always @(negedge clk) begin
      if (rst_n && pred_valid_i) begin
         if (exp_q.size() == 0) begin
            note(1'b0, "R2 unexpected prediction", {pred_taken_o, pred_meta_o}, '0);
         end else begin
            logic [META_W:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            note({pred_taken_o, pred_meta_o} == e, t, {pred_taken_o, pred_meta_o}, e);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [META_W-1:0] m, ma, mb, prev_m;
      logic [PC_W-1:0]   pc, prev_pc;
      logic [31:0]       lfsr;

      model_reset();
      do_reset();

      // R1: reset value at the ports, then first prediction
      #1;
      note(pred_meta_o[META_W-1:2] == '0, "R1 history after reset",
           {1'b0, pred_meta_o}, '0);
      pred(32'h100, "R1", m);
      note(m == {10'd0, 1'b1, 1'b1}, "R1 first meta", {1'b0, m}, {1'b0, 10'd0, 2'b11});
      // R5: history collects predicted directions, R2 field layout
      pred(32'h104, "R5", m);
      pred(32'h108, "R5", m);
      pred(32'h10c, "R2", m);
      note(m[META_W-1:2] == 10'd7, "R5 history after three taken", {1'b0, m}, {1'b0, 10'd7, 2'b11});
      // R10: idle cycles keep the history
      idle(4);
      pred(32'h110, "R10", m);
      // R6: mispredicted update repairs history
      upd(32'h10c, 1'b0, {10'd7, 2'b11});
      pred(32'h114, "R6", m);
      note(m[META_W-1:2] == 10'd14, "R6 repaired history", {1'b0, m}, {1'b0, 10'd14, 2'b00});
      // R6: repair wins over a same-cycle prediction
      do_op(1'b1, 32'h118, "R6", 1'b1, 32'h114, 1'b0, m, ma);
      pred(32'h11c, "R6", m);
      // R7: correct update leaves history
      upd(32'h11c, m[0], m);
      pred(32'h120, "R7", m);
      idle(1);

      // R8: only the selected bank learns
      do_reset();
      upd(32'h200, 1'b1, {10'd0, 2'b01});
      upd(32'h200, 1'b0, {10'd0, 2'b11});
      pred(32'h200, "R8", m);
      note(m[1:0] == 2'b01, "R8 not-taken bank trained alone", {1'b0, m}, {1'b0, 10'd0, 2'b01});
      // R8: saturation
      for (int i = 0; i < 5; i++) upd(32'h300, 1'b0, {10'd0, 2'b00});
      upd(32'h300, 1'b1, {10'd0, 2'b00});
      idle(1);
      pred(32'h300, "R8", m);
      idle(1);

      // R9: choice kept when it chose wrongly but its bank was right
      do_reset();
      pred(32'h200, "R4", ma);
      upd(32'h200, 1'b1, ma);
      pred(32'h200, "R4", mb);
      upd(32'h200, 1'b0, mb);
      upd(32'h200, 1'b0, {10'd1, 2'b10});
      pred(32'h200, "R9", m);
      note(m[1] == 1'b1, "R9 choice unchanged", {1'b0, m}, {1'b0, m[META_W-1:2], 1'b1, m[0]});
      idle(1);

      // R3: mixed stream with overlapping predict and update
      do_reset();
      lfsr = 32'hACE1_2357;
      prev_pc = 32'h1000;
      pred(prev_pc, "R3", prev_m);
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         pc = 32'h1000 + {24'd0, lfsr[5:0], 2'b00};
         do_op(1'b1, pc, "R3", 1'b1, prev_pc, lfsr[9] | prev_pc[2], prev_m, m);
         prev_pc = pc; prev_m = m;
      end
      idle(2);
      note(exp_q.size() == 0, "R4 scoreboard drained", {1'b0, 12'(exp_q.size())}, '0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule